// File: doc/BRIEF.md
# TIC-Aligned Timemark Generator

This block turns a periodic TIC strobe from a timebase into a raw timemark pulse, the kind used as a once-per-second marker. Every timemark is tied to a TIC. The only way to move the timemark against an outside time reference is to move TIC itself. A seven-bit control word picks the mode.

In one-shot mode, software sets the arm bit. The next TIC fires one pulse, and hardware then clears the arm bit. Software can poll the readback to see that the pulse has happened. In free-running mode, the block divides the TIC stream by a programmed ratio and fires with no further software action.

The block also divides the master clock down to a 100 kHz reference. This reference is a one-cycle clock-enable strobe. It has the accuracy of the master clock and is never resynchronised to anything else.

Top module: `tmark_gen`

## Requirements
- R1: After reset, `cfg_rdata` is 0, `timemark` is 0 and `ref_en` is 0.
- R2: Control word fields are: bit 0 = arm, bit 1 = free-run select, bits 6:2 = free-run ratio. A write shows on `cfg_rdata` in the cycle after `cfg_we`. Bits 6:1 read back exactly as written.
- R3: With free-run = 0 and arm = 1, a TIC sampled in cycle t makes `timemark` high in cycle t+1, for that one cycle only.
- R4: When a one-shot pulse fires, the arm bit reads 0 in the same cycle that `timemark` is high. Later TICs make no pulse until the block is armed again.
- R5: `timemark` is never high unless TIC was high in the cycle before. An armed block with no TIC stays silent and keeps arm = 1.
- R6: With free-run = 1 and ratio N (1 to 31), pulses follow the N-th, 2N-th, and later TICs. TICs are counted from the write that selected the mode, with a TIC in that write's cycle counting as the first.
- R7: A free-run ratio of 0 behaves as 1, so every TIC gives a pulse.
- R8: Any write that has free-run = 1 restarts the TIC count, even when the ratio is unchanged.
- R9: A write in the same cycle as a TIC takes effect before that TIC. Writing arm = 1 with free-run = 0 on a TIC cycle fires on that TIC, and the arm bit still reads back as 0.
- R10: `ref_en` is high for exactly one cycle in every REF_DIV master-clock cycles. REF_DIV defaults to 1250, which gives 100 kHz from 125 MHz.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| tic | input | 1 | One-cycle TIC strobe from the timebase |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 7 | Control word write data |
| cfg_rdata | output | 7 | Control word readback |
| timemark | output | 1 | Registered raw timemark pulse |
| ref_en | output | 1 | 100 kHz clock-enable strobe |

## Verification
Each result passes through one register.
- A timemark appears in the cycle after its TIC.
- The readback changes in the cycle after a write, and in the cycle after a one-shot TIC for the cleared arm bit.
- The reference strobe repeats every REF_DIV cycles.

The bench drives inputs on the falling edge and holds each strobe for one cycle. It samples on the next falling edge, which is exactly where the registered result lands. It also looks at the cycle before, to confirm that nothing shows early.

The reference period is measured by counting falling edges between two strobes. A second count confirms the strobe lasts a single cycle.

// File: rtl/tmark_pkg.sv
package tmark_pkg;

    localparam int RATIO_W = 5;
    localparam int CFG_W   = RATIO_W + 2;

    // Control word: arm at bit 0, free-run at bit 1, ratio above
    typedef struct packed {
        logic [RATIO_W-1:0] ratio;
        logic               free;
        logic               arm;
    } tm_cfg_t;

    // Ratio 0 behaves as 1
    function automatic logic [RATIO_W:0] ratio_or_one(input logic [RATIO_W-1:0] r);
        logic [RATIO_W:0] v;
        v = {1'b0, r};
        if (r == '0) v = {{RATIO_W{1'b0}}, 1'b1};
        return v;
    endfunction

endpackage

// File: rtl/tmark_cfg_reg.sv
module tmark_cfg_reg
    import tmark_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    we,
    input  tm_cfg_t wdata,
    input  logic    clr_arm,
    output tm_cfg_t cfg_q,
    output tm_cfg_t cfg_eff,
    output logic    restart
);

    tm_cfg_t cfg_r;

    // A write in this cycle is seen by the fire logic at once
    assign cfg_eff = we ? wdata : cfg_r;
    assign restart = we & wdata.free;
    assign cfg_q   = cfg_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_r <= '0;
        end else begin
            if (we) cfg_r <= wdata;
            // Hardware clear of arm wins over a software set on a TIC cycle
            if (clr_arm) cfg_r.arm <= 1'b0;
        end
    end

endmodule

// File: rtl/tmark_fire.sv
module tmark_fire
    import tmark_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    tic,
    input  tm_cfg_t cfg_eff,
    input  logic    restart,
    output logic    clr_arm,
    output logic    timemark
);

    logic [RATIO_W-1:0] cnt_q;
    logic [RATIO_W-1:0] cnt_base;
    logic [RATIO_W:0]   cnt_inc;
    logic [RATIO_W:0]   ratio_n;
    logic               wrap;
    logic               fire_free;
    logic               fire_arm;
    logic               mark_q;

    always_comb begin
        cnt_base  = restart ? '0 : cnt_q;
        cnt_inc   = {1'b0, cnt_base} + 1'b1;
        ratio_n   = ratio_or_one(cfg_eff.ratio);
        wrap      = (cnt_inc >= ratio_n);
        fire_free = tic & cfg_eff.free & wrap;
        fire_arm  = tic & ~cfg_eff.free & cfg_eff.arm;
    end

    assign clr_arm  = fire_arm;
    assign timemark = mark_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (tic & cfg_eff.free) begin
            cnt_q <= wrap ? '0 : cnt_inc[RATIO_W-1:0];
        end else if (restart) begin
            cnt_q <= '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) mark_q <= 1'b0;
        else     mark_q <= fire_free | fire_arm;
    end

endmodule

// File: rtl/tmark_refdiv.sv
module tmark_refdiv #(
    parameter int DIV = 1250
) (
    input  logic clk,
    input  logic rst,
    output logic ref_en
);

    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;
    logic          en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            en_q  <= 1'b0;
        end else begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
            en_q  <= (cnt_q == LAST);
        end
    end

    assign ref_en = en_q;

endmodule

// File: rtl/tmark_gen.sv
module tmark_gen
    import tmark_pkg::*;
#(
    parameter int REF_DIV = 1250
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tic,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    output logic             timemark,
    output logic             ref_en
);

    tm_cfg_t cfg_q;
    tm_cfg_t cfg_eff;
    logic    restart;
    logic    clr_arm;

    tmark_cfg_reg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .we      (cfg_we),
        .wdata   (tm_cfg_t'(cfg_wdata)),
        .clr_arm (clr_arm),
        .cfg_q   (cfg_q),
        .cfg_eff (cfg_eff),
        .restart (restart)
    );

    tmark_fire u_fire (
        .clk      (clk),
        .rst      (rst),
        .tic      (tic),
        .cfg_eff  (cfg_eff),
        .restart  (restart),
        .clr_arm  (clr_arm),
        .timemark (timemark)
    );

    tmark_refdiv #(.DIV(REF_DIV)) u_ref (
        .clk    (clk),
        .rst    (rst),
        .ref_en (ref_en)
    );

    assign cfg_rdata = cfg_q;

endmodule

// File: rtl/tmark_chk.sv
module tmark_chk #(
    parameter int REF_DIV = 1250
) (
    input logic       clk,
    input logic       rst,
    input logic       tic,
    input logic       cfg_we,
    input logic [6:0] cfg_wdata,
    input logic [6:0] cfg_rdata,
    input logic       timemark,
    input logic       ref_en
);

    logic [31:0] gap;
    logic        seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap  <= '0;
            seen <= 1'b0;
        end else if (ref_en) begin
            gap  <= '0;
            seen <= 1'b1;
        end else begin
            gap  <= gap + 1;
        end
    end

    // R2
    readback_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> cfg_rdata[6:1] == $past(cfg_wdata[6:1]));

    // R3
    armed_fire_chk: assert property (@(posedge clk) disable iff (rst)
        (tic && !cfg_we && !cfg_rdata[1] && cfg_rdata[0]) |=> timemark);

    // R4
    arm_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (timemark && !cfg_rdata[1]) |-> !cfg_rdata[0]);

    // R5
    tic_aligned_chk: assert property (@(posedge clk) disable iff (rst)
        timemark |-> $past(tic));

    // R10
    ref_width_chk: assert property (@(posedge clk) disable iff (rst)
        ref_en |=> !ref_en);

    // R10
    ref_period_chk: assert property (@(posedge clk) disable iff (rst)
        (ref_en && seen) |-> gap == REF_DIV - 1);

endmodule

bind tmark_gen tmark_chk #(.REF_DIV(REF_DIV)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .tic       (tic),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .timemark  (timemark),
    .ref_en    (ref_en)
);

// File: tb/tmark_gen_test.sv
`timescale 1ns/1ps
module tmark_gen_test;

    localparam int REF_DIV = 1250;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tic = 1'b0;
    logic       cfg_we = 1'b0;
    logic [6:0] cfg_wdata = '0;
    logic [6:0] cfg_rdata;
    logic       timemark;
    logic       ref_en;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    tmark_gen #(.REF_DIV(REF_DIV)) uut (
        .clk       (clk),
        .rst       (rst),
        .tic       (tic),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .timemark  (timemark),
        .ref_en    (ref_en)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [6:0] word(input int ratio, input bit fr, input bit arm);
        return {ratio[4:0], fr, arm};
    endfunction

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic write_cfg(input logic [6:0] w);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = w;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // One TIC, then return the timemark due in the following cycle
    task automatic send_tic(output logic got, output logic early);
        @(negedge clk);
        tic = 1'b1;
        early = timemark;
        @(negedge clk);
        tic = 1'b0;
        got = timemark;
    endtask

    task automatic t_reset;
        check("R1 rdata", cfg_rdata, 0);
        check("R1 timemark", timemark, 0);
        check("R1 ref_en", ref_en, 0);
    endtask

    task automatic t_readback;
        write_cfg(word(21, 1'b0, 1'b0));
        check("R2 readback ratio", cfg_rdata, {5'd21, 2'b00});
        write_cfg(word(9, 1'b1, 1'b0));
        check("R2 readback free", cfg_rdata, {5'd9, 2'b10});
        write_cfg(word(0, 1'b0, 1'b0));
    endtask

    task automatic t_armed;
        logic g, e;
        write_cfg(word(0, 1'b0, 1'b1));
        check("R2 arm readback", cfg_rdata[0], 1);
        idle(10);
        check("R5 no tic no pulse", timemark, 0);
        check("R5 arm held", cfg_rdata[0], 1);
        send_tic(g, e);
        check("R3 pulse after tic", g, 1);
        check("R3 not early", e, 0);
        check("R4 arm cleared", cfg_rdata[0], 0);
        @(negedge clk);
        check("R3 one cycle wide", timemark, 0);
        idle(2);
        send_tic(g, e);
        check("R4 no repeat", g, 0);
    endtask

    task automatic t_arm_on_tic;
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = word(0, 1'b0, 1'b1); tic = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0; tic = 1'b0;
        check("R9 fire on write tic", timemark, 1);
        check("R9 arm cleared", cfg_rdata[0], 0);
        @(negedge clk);
        check("R9 pulse ended", timemark, 0);
    endtask

    task automatic t_free(input int n);
        logic g, e;
        write_cfg(word(n, 1'b1, 1'b0));
        for (int k = 1; k <= 3 * n; k++) begin
            send_tic(g, e);
            check($sformatf("R6 ratio %0d tic %0d", n, k), g, (k % n) == 0);
            idle(1);
        end
    endtask

    task automatic t_ratio_zero;
        logic g, e;
        write_cfg(word(0, 1'b1, 1'b0));
        for (int k = 0; k < 4; k++) begin
            send_tic(g, e);
            check("R7 ratio zero", g, 1);
            idle(2);
        end
    endtask

    task automatic t_restart;
        logic g, e;
        write_cfg(word(4, 1'b1, 1'b0));
        send_tic(g, e); idle(1);
        send_tic(g, e); idle(1);
        write_cfg(word(4, 1'b1, 1'b0));
        for (int k = 1; k <= 4; k++) begin
            send_tic(g, e);
            check($sformatf("R8 restart tic %0d", k), g, k == 4);
            idle(1);
        end
        write_cfg(word(0, 1'b0, 1'b0));
    endtask

    task automatic t_refclk;
        int n;
        n = 0;
        while (ref_en !== 1'b1 && n < 3 * REF_DIV) begin
            @(negedge clk); n++;
        end
        check("R10 strobe seen", ref_en, 1);
        @(negedge clk);
        check("R10 single cycle", ref_en, 0);
        n = 1;
        while (ref_en !== 1'b1 && n < 3 * REF_DIV) begin
            @(negedge clk); n++;
        end
        check("R10 period", n, REF_DIV);
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        t_reset;
        rst = 1'b0;
        t_readback;
        t_armed;
        t_arm_on_tic;
        t_free(1);
        t_free(3);
        t_free(5);
        t_ratio_zero;
        t_restart;
        t_refclk;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule